// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Unit

This block turns a row of already-filtered pin levels into sticky interrupt and wake status, one pair of status bits per pin. Each pin has its own trigger configuration: a sense-mode bit picks edge or level detection, and a two-bit polarity field picks the active sense. Together they give active-high, active-low or either-edge detection. An enable bit decides whether a pin may record status at all. A separate unmask bit decides only whether recorded status is reported as pending. Because of this split, a masked pin still captures its events.

Wake status is the interrupt event again, qualified by the current system sleep state. The state arrives as a two-bit input from a power controller outside the block. Each pin holds three wake-enable bits, one per sleep state. Software clears status by pulsing a write-one-to-clear strobe for the pin, with separate strobes for interrupt and wake status. Debouncing happens upstream of this block.

Top module: `pit_irq_unit`

## Requirements
- R1: After reset every interrupt-status, wake-status and pending output is 0.
- R2: In edge mode (sense-mode bit 0) with polarity code 2'b00, interrupt status sets in the cycle after the filtered input goes from 0 to 1. A steady high level does not set it again, and a falling edge does not set it.
- R3: In edge mode with polarity code 2'b01, interrupt status sets on a 1-to-0 transition only.
- R4: In edge mode with polarity code 2'b10, interrupt status sets on either transition.
- R5: In level mode (sense-mode bit 1), polarity 2'b00 sets status whenever the input is 1 and polarity 2'b01 sets it whenever the input is 0. The set repeats every cycle, so a clear strobe has no effect while the active level persists. Status clears once the level is gone.
- R6: Polarity 2'b10 in level mode and polarity 2'b11 in either mode never set status.
- R7: With the pin's enable bit 0, neither interrupt nor wake status sets, and status already held is retained.
- R8: A clear strobe bit of 1 clears that pin's interrupt status (or wake status, for the wake strobe) in the next cycle. It leaves other pins and the other status kind untouched.
- R9: When a set event and a clear strobe hit the same pin in the same cycle, the status ends up set.
- R10: Wake status sets along with interrupt status only when the sleep state input selects an enabled wake bit. State 2'b00 (running) never produces wake status. State 2'b01 uses wake-enable bit 0, 2'b10 uses bit 1, and 2'b11 uses bit 2 of the pin's three-bit field.
- R11: A pin's pending output is 1 exactly when its interrupt or wake status is 1 and its unmask bit is 1. Status is captured even while the pin is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | N_PINS | Filtered pin levels |
| cfg_level | input | N_PINS | Sense mode per pin: 1 level, 0 edge |
| cfg_pol | input | 2*N_PINS | Polarity code per pin, pin i at bits [2i+1:2i] |
| cfg_irq_en | input | N_PINS | Status generation enable per pin |
| cfg_unmask | input | N_PINS | Pending report enable per pin |
| cfg_wake_en | input | 3*N_PINS | Wake enables per pin, pin i at bits [3i+2:3i] |
| pwr_state | input | 2 | Current sleep state code |
| clr_irq | input | N_PINS | Write-one-to-clear strobes for interrupt status |
| clr_wake | input | N_PINS | Write-one-to-clear strobes for wake status |
| irq_sts | output | N_PINS | Sticky interrupt status |
| wake_sts | output | N_PINS | Sticky wake status |
| pend | output | N_PINS | Qualified pending per pin |

## Verification
The bench attacks the collision of a set event with a clear strobe on the same pin. A design that lets the clear win would lose an edge that arrives during service. It pulses clear while a level-mode source stays active, where a wrong design would show status dropping and lose a still-asserted request. It also toggles the input with polarity codes that are invalid for the current mode; a design that accepts both-edge sensing in level mode would raise status on every cycle. Finally it steps through all four sleep-state codes with different wake-enable fields, and it masks a pin while an event arrives. A wrong bit selection or mask gating shows up as stray or missing wake status, or as lost captured status.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int POL_W  = 2;
  localparam int WAKE_W = 3;

  typedef enum logic [1:0] {
    POL_HIGH = 2'b00,
    POL_LOW  = 2'b01,
    POL_BOTH = 2'b10,
    POL_NONE = 2'b11
  } pol_e;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'b00,
    PWR_IDLE  = 2'b01,
    PWR_SUSP  = 2'b10,
    PWR_HIBER = 2'b11
  } pwr_e;

  // Trigger decision for one pin from its sense mode, polarity and input events.
  function automatic logic trig_hit(input logic lvl_mode, input logic [1:0] pol,
                                    input logic cur, input logic rise, input logic fall);
    logic h;
    h = 1'b0;
    if (lvl_mode) begin
      case (pol)
        POL_HIGH: h = cur;
        POL_LOW:  h = ~cur;
        default:  h = 1'b0;
      endcase
    end else begin
      case (pol)
        POL_HIGH: h = rise;
        POL_LOW:  h = fall;
        POL_BOTH: h = rise | fall;
        default:  h = 1'b0;
      endcase
    end
    return h;
  endfunction

  // Wake qualification: running state never wakes, other states pick one enable bit.
  function automatic logic wake_gate(input logic [1:0] st, input logic [WAKE_W-1:0] en);
    logic g;
    case (st)
      PWR_IDLE:  g = en[0];
      PWR_SUSP:  g = en[1];
      PWR_HIBER: g = en[2];
      default:   g = 1'b0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/pit_edge_detect.sv
module pit_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/pit_trigger_sel.sv
module pit_trigger_sel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_mode,
  input  logic [POL_W-1:0]  pol,
  input  logic              cur,
  input  logic              rise,
  input  logic              fall,
  input  logic              en,
  input  logic [WAKE_W-1:0] wake_en,
  input  logic [1:0]        pwr_state,
  output logic              hit,
  output logic              irq_set,
  output logic              wake_set
);
  assign hit      = trig_hit(lvl_mode, pol, cur, rise, fall);
  assign irq_set  = en & hit;
  assign wake_set = irq_set & wake_gate(pwr_state, wake_en);

  // R6: both-edge code in level mode never triggers
  assert_no_both_in_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && pol == POL_BOTH) |-> !hit);
  // R6: reserved polarity code never triggers
  assert_no_reserved_pol_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_NONE) |-> !hit);
endmodule

// File: rtl/pit_sticky_bit.sv
module pit_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic sts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sts <= 1'b0;
    else if (set_req) sts <= 1'b1;
    else if (clr_req) sts <= 1'b0;
  end

  // R9: set wins over a simultaneous clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> sts);
  // R8: clear without set empties the bit
  assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !sts);
  // R7: status never appears without a set request
  assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts && !set_req) |=> !sts);
endmodule

// File: rtl/pit_irq_unit.sv
module pit_irq_unit
  import pit_pkg::*;
#(
  parameter int N_PINS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PINS-1:0]        pin_lvl,
  input  logic [N_PINS-1:0]        cfg_level,
  input  logic [N_PINS*POL_W-1:0]  cfg_pol,
  input  logic [N_PINS-1:0]        cfg_irq_en,
  input  logic [N_PINS-1:0]        cfg_unmask,
  input  logic [N_PINS*WAKE_W-1:0] cfg_wake_en,
  input  logic [1:0]               pwr_state,
  input  logic [N_PINS-1:0]        clr_irq,
  input  logic [N_PINS-1:0]        clr_wake,
  output logic [N_PINS-1:0]        irq_sts,
  output logic [N_PINS-1:0]        wake_sts,
  output logic [N_PINS-1:0]        pend
);
  localparam int POL_BITS  = N_PINS * POL_W;
  localparam int WAKE_BITS = N_PINS * WAKE_W;

  logic [N_PINS-1:0] rise_w, fall_w, hit_w, irq_set_w, wake_set_w;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    pit_edge_detect u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (pin_lvl[i]),
      .rise (rise_w[i]),
      .fall (fall_w[i])
    );

    pit_trigger_sel u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_mode (cfg_level[i]),
      .pol      (cfg_pol[i*POL_W +: POL_W]),
      .cur      (pin_lvl[i]),
      .rise     (rise_w[i]),
      .fall     (fall_w[i]),
      .en       (cfg_irq_en[i]),
      .wake_en  (cfg_wake_en[i*WAKE_W +: WAKE_W]),
      .pwr_state(pwr_state),
      .hit      (hit_w[i]),
      .irq_set  (irq_set_w[i]),
      .wake_set (wake_set_w[i])
    );

    pit_sticky_bit u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_req(irq_set_w[i]),
      .clr_req(clr_irq[i]),
      .sts    (irq_sts[i])
    );

    pit_sticky_bit u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_req(wake_set_w[i]),
      .clr_req(clr_wake[i]),
      .sts    (wake_sts[i])
    );

    assign pend[i] = (irq_sts[i] | wake_sts[i]) & cfg_unmask[i];

    // R2: enabled rising edge in edge/high mode is captured
    assert_rise_captured_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_level[i] && cfg_pol[i*POL_W +: POL_W] == POL_HIGH && cfg_irq_en[i] && rise_w[i])
      |=> irq_sts[i]);
    // R10: running state never raises wake status
    assert_no_wake_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == PWR_RUN && !wake_sts[i]) |=> !wake_sts[i]);
    // R10: wake status only rises together with interrupt status
    assert_wake_with_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_sts[i]) |-> irq_sts[i]);
  end

  // R1: nothing pending out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_sts == '0 && wake_sts == '0));

  if (POL_BITS != N_PINS * 2 || WAKE_BITS != N_PINS * 3) begin : g_bad_width
    initial $error("pit_irq_unit: field width mismatch");
  end
endmodule

// File: tb/test_pit_irq_unit.sv
`timescale 1ns/1ps
module test_pit_irq_unit;
  localparam int N = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] pin_lvl, cfg_level, cfg_irq_en, cfg_unmask, clr_irq, clr_wake;
  logic [2*N-1:0] cfg_pol;
  logic [3*N-1:0] cfg_wake_en;
  logic [1:0]   pwr_state;
  logic [N-1:0] irq_sts, wake_sts, pend;

  pit_irq_unit #(.N_PINS(N)) i_pit_irq_unit (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cfg_level(cfg_level),
    .cfg_pol(cfg_pol), .cfg_irq_en(cfg_irq_en), .cfg_unmask(cfg_unmask),
    .cfg_wake_en(cfg_wake_en), .pwr_state(pwr_state), .clr_irq(clr_irq),
    .clr_wake(clr_wake), .irq_sts(irq_sts), .wake_sts(wake_sts), .pend(pend)
  );

  typedef struct {
    logic [N-1:0] irq;
    logic [N-1:0] wake;
    logic [N-1:0] pnd;
    string        tag;
  } exp_t;

  exp_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit mon_on = 0;
  bit finished = 0;

  task automatic cmp(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: inputs already set at a falling edge; queue the outcome of the next rising edge.
  task automatic cyc(string tag, logic [N-1:0] ei, logic [N-1:0] ew);
    exp_t e;
    e.irq  = ei;
    e.wake = ew;
    e.pnd  = (ei | ew) & cfg_unmask;   // R11 rule
    e.tag  = tag;
    q.push_back(e);
    @(negedge clk);
    clr_irq  = '0;
    clr_wake = '0;
  endtask

  // Monitor: compares after each rising edge.
  initial begin
    wait (mon_on);
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "irq_sts", irq_sts, e.irq);
        cmp(e.tag, "wake_sts", wake_sts, e.wake);
        cmp(e.tag, "pend", pend, e.pnd);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pin_lvl = '0; cfg_level = '0; cfg_pol = '0; cfg_irq_en = '0;
    cfg_unmask = '0; cfg_wake_en = '0; pwr_state = 2'b00; clr_irq = '0; clr_wake = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp("R1", "irq_sts", irq_sts, '0);
    cmp("R1", "wake_sts", wake_sts, '0);
    cmp("R1", "pend", pend, '0);
    mon_on = 1;
    cfg_irq_en = '1; cfg_unmask = '1;

    // R2 edge, high polarity on pin 0
    pin_lvl[0] = 1;                 cyc("R2 rise", 4'b0001, 4'b0000);
    clr_irq[0] = 1;                 cyc("R2 clear", 4'b0000, 4'b0000);
    cyc("R2 steady high", 4'b0000, 4'b0000);
    pin_lvl[0] = 0;                 cyc("R2 fall ignored", 4'b0000, 4'b0000);

    // R3 falling edge on pin 1
    cfg_pol[3:2] = 2'b01;
    pin_lvl[1] = 1;                 cyc("R3 rise ignored", 4'b0000, 4'b0000);
    pin_lvl[1] = 0;                 cyc("R3 fall", 4'b0010, 4'b0000);
    clr_irq[1] = 1;                 cyc("R3 clear", 4'b0000, 4'b0000);

    // R4 both edges on pin 2
    cfg_pol[5:4] = 2'b10;
    pin_lvl[2] = 1;                 cyc("R4 rise", 4'b0100, 4'b0000);
    clr_irq[2] = 1;                 cyc("R4 clear", 4'b0000, 4'b0000);
    pin_lvl[2] = 0;                 cyc("R4 fall", 4'b0100, 4'b0000);
    clr_irq[2] = 1;                 cyc("R4 clear2", 4'b0000, 4'b0000);

    // R9 set and clear together on pin 0
    pin_lvl[0] = 1; clr_irq[0] = 1; cyc("R9 set wins", 4'b0001, 4'b0000);
    clr_irq[0] = 1;                 cyc("R9 later clear", 4'b0000, 4'b0000);
    pin_lvl[0] = 0;                 cyc("R9 idle", 4'b0000, 4'b0000);

    // R5 level mode on pin 3
    cfg_level[3] = 1; pin_lvl[3] = 1; cyc("R5 high level", 4'b1000, 4'b0000);
    clr_irq[3] = 1;                 cyc("R5 clear blocked", 4'b1000, 4'b0000);
    pin_lvl[3] = 0; clr_irq[3] = 1; cyc("R5 clear after drop", 4'b0000, 4'b0000);
    cfg_pol[7:6] = 2'b01;           cyc("R5 low level", 4'b1000, 4'b0000);
    pin_lvl[3] = 1; clr_irq[3] = 1; cyc("R5 low gone", 4'b0000, 4'b0000);

    // R6 invalid codes
    cfg_pol[7:6] = 2'b10;
    pin_lvl[3] = 0;                 cyc("R6 both in level", 4'b0000, 4'b0000);
    pin_lvl[3] = 1;                 cyc("R6 both in level 2", 4'b0000, 4'b0000);
    cfg_pol[7:6] = 2'b11;
    pin_lvl[3] = 0;                 cyc("R6 reserved level", 4'b0000, 4'b0000);
    cfg_pol[3:2] = 2'b11;
    pin_lvl[1] = 1;                 cyc("R6 reserved edge", 4'b0000, 4'b0000);
    pin_lvl[1] = 0;                 cyc("R6 reserved edge 2", 4'b0000, 4'b0000);
    cfg_pol[3:2] = 2'b01; cfg_level[3] = 0; cfg_pol[7:6] = 2'b00;
    cyc("R6 restore", 4'b0000, 4'b0000);

    // R7 enable off
    cfg_irq_en[0] = 0; pin_lvl[0] = 1; cyc("R7 disabled edge", 4'b0000, 4'b0000);
    pin_lvl[1] = 1;                 cyc("R7 prep", 4'b0000, 4'b0000);
    pin_lvl[1] = 0;                 cyc("R7 prep set", 4'b0010, 4'b0000);
    cfg_irq_en[1] = 0;              cyc("R7 retained", 4'b0010, 4'b0000);
    pin_lvl[1] = 1;                 cyc("R7 retained 2", 4'b0010, 4'b0000);
    pin_lvl[1] = 0;                 cyc("R7 retained 3", 4'b0010, 4'b0000);
    clr_irq[1] = 1;                 cyc("R7 clear", 4'b0000, 4'b0000);
    cfg_irq_en = '1;                cyc("R7 reenable no edge", 4'b0000, 4'b0000);
    pin_lvl[0] = 0;                 cyc("R7 idle", 4'b0000, 4'b0000);

    // R11 masked capture
    cfg_unmask[0] = 0; pin_lvl[0] = 1; cyc("R11 masked capture", 4'b0001, 4'b0000);
    cfg_unmask = '1;                cyc("R11 unmask shows", 4'b0001, 4'b0000);
    clr_irq[0] = 1;                 cyc("R11 clear", 4'b0000, 4'b0000);
    pin_lvl[0] = 0;                 cyc("R11 idle", 4'b0000, 4'b0000);

    // R10 wake gating, pin 0
    cfg_wake_en[2:0] = 3'b001;
    pin_lvl[0] = 1;                 cyc("R10 running no wake", 4'b0001, 4'b0000);
    clr_irq[0] = 1; pin_lvl[0] = 0; cyc("R10 clear", 4'b0000, 4'b0000);
    pwr_state = 2'b01;
    pin_lvl[0] = 1;                 cyc("R10 state1 wake", 4'b0001, 4'b0001);
    clr_wake[0] = 1;                cyc("R8 wake clear only", 4'b0001, 4'b0000);
    clr_irq[0] = 1;                 cyc("R8 irq clear", 4'b0000, 4'b0000);
    pwr_state = 2'b10;
    pin_lvl[0] = 0;                 cyc("R10 idle", 4'b0000, 4'b0000);
    pin_lvl[0] = 1;                 cyc("R10 state2 disabled", 4'b0001, 4'b0000);
    clr_irq[0] = 1; pin_lvl[0] = 0; cyc("R10 clear2", 4'b0000, 4'b0000);
    cfg_wake_en[2:0] = 3'b010;
    pin_lvl[0] = 1;                 cyc("R10 state2 enabled", 4'b0001, 4'b0001);
    pwr_state = 2'b11; cfg_wake_en[5:3] = 3'b100;
    pin_lvl[1] = 1;                 cyc("R10 pin1 prep", 4'b0001, 4'b0001);
    pin_lvl[1] = 0;                 cyc("R10 state3 wake", 4'b0011, 4'b0011);
    clr_irq[0] = 1; clr_wake[0] = 1; cyc("R8 per pin clear", 4'b0010, 4'b0010);
    clr_irq[1] = 1; clr_wake[1] = 1; cyc("R8 clear pin1", 4'b0000, 4'b0000);

    // R7 wake also blocked when disabled
    cfg_wake_en[2:0] = 3'b100; cfg_irq_en[0] = 0;
    pin_lvl[0] = 0;                 cyc("R7 wake prep", 4'b0000, 4'b0000);
    pin_lvl[0] = 1;                 cyc("R7 no wake disabled", 4'b0000, 4'b0000);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule